// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit sits beside the receive and transmit machinery of a 16550-style serial port. It sorts that port's interrupt sources by priority and shows the host a read-only identification byte with an interrupt request line. Five sources are tracked: receiver line errors, receive data at or above the FIFO trigger level, receive character timeout, transmit holding register empty, and modem-line changes. Each source has its own enable bit. Host access strobes clear the sources, and each source has its own clearing rule.

All source state is held in registers. The byte and the request line are decoded from those registers, so any stimulus shows up one rising edge later. While the host holds the identification read strobe, the source state does not move. Events that arrive during that read are collected on the side and merged once the read ends. At that same point, a pending transmit-empty interrupt is retired if the read reported it.

Top module: `uart_irq_ident`

## Requirements
- R1: With nothing enabled and pending, the byte's bits 3:0 read 4'b0001 and irq is low. irq is high exactly when bit 0 of the byte is 0.
- R2: Bits 3:1 report the highest-priority enabled pending source. In order: line error 3'b011, receive timeout 3'b110, receive data at trigger 3'b010, transmit empty 3'b001, modem change 3'b000.
- R3: Bits 7 and 6 both equal the registered fifo_en. Bits 5 and 4 always read 0.
- R4: Outside an identification read, a change on any source, enable, fifo_en or clear strobe appears at the byte after exactly one rising clock edge.
- R5: While rd_iir is high, the byte and all source state stay frozen. Events that arrive in that window are recorded and appear one edge after rd_iir falls.
- R6: A pulse on any ls_err bit sets the line-error source. An rd_lsr strobe clears it.
- R7: The receive-data source follows rx_at_trig and clears when rx_at_trig falls. An rx_tmo pulse sets the timeout source, and an rd_rbr strobe clears it.
- R8: A thr_empty pulse sets the transmit-empty source. It is cleared by wr_thr, or when an identification read ends that reported code 3'b001 with bit 0 low. A read that reported another source leaves it pending.
- R9: A pulse on any ms_delta bit sets the modem source. An rd_msr strobe clears it.
- R10: Enable bits are ier[0] for receive data and timeout, ier[1] for transmit empty, ier[2] for line error, and ier[3] for modem. A disabled source keeps its pending state but is neither reported nor drives irq.
- R11: If a set event and a clear strobe for the same source arrive on the same edge, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Per-source interrupt enables |
| fifo_en | input | 1 | FIFO mode setting |
| ls_err | input | LS_W | Line error event pulses (overrun, parity, framing, break) |
| rx_at_trig | input | 1 | Receive FIFO level at or above trigger |
| rx_tmo | input | 1 | Receive character timeout event |
| thr_empty | input | 1 | Transmit holding register became empty |
| ms_delta | input | MS_W | Modem line change pulses |
| rd_lsr | input | 1 | Host read of line status |
| rd_rbr | input | 1 | Host read of receive FIFO |
| rd_iir | input | 1 | Host identification read in progress |
| rd_msr | input | 1 | Host read of modem status |
| wr_thr | input | 1 | Host write of transmit holding register |
| iir_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every result is due one rising edge after its stimulus: events, level changes, enable changes and clear strobes each pass through one register before they reach the decoded byte. The bench drives inputs just after a falling edge and samples at the next falling edge, which lands each check half a cycle after the edge that produced it. Freeze checks sample once per cycle while rd_iir is held, then once more one edge after it drops, to catch the deferred events and the transmit-empty retirement.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [2:0] {
        ID_MODEM  = 3'b000,
        ID_THRE   = 3'b001,
        ID_RXDATA = 3'b010,
        ID_LINE   = 3'b011,
        ID_RXTMO  = 3'b110
    } iid_code_e;

    typedef struct packed {
        logic line;
        logic rxtmo;
        logic rxdata;
        logic thre;
        logic modem;
    } iid_src_t;

    typedef struct packed {
        logic [1:0] fifo_on;
        logic [1:0] zero;
        iid_code_e  id;
        logic       none;
    } iid_byte_t;

    localparam int NSTICKY  = 4;
    localparam int SK_LINE  = 0;
    localparam int SK_TMO   = 1;
    localparam int SK_THRE  = 2;
    localparam int SK_MODEM = 3;

    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    function automatic iid_byte_t iid_encode(input iid_src_t act, input logic fifo_on);
        iid_byte_t b;
        b.fifo_on = {2{fifo_on}};
        b.zero    = 2'b00;
        b.none    = 1'b0;
        if (act.line)        b.id = ID_LINE;
        else if (act.rxtmo)  b.id = ID_RXTMO;
        else if (act.rxdata) b.id = ID_RXDATA;
        else if (act.thre)   b.id = ID_THRE;
        else begin
            b.id   = ID_MODEM;
            b.none = ~act.modem;
        end
        return b;
    endfunction

endpackage

// File: rtl/uart_iid_src.sv
module uart_iid_src
    import uart_iid_pkg::*;
#(
    parameter int LS_W = 4,
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      ier,
    input  logic            fifo_en,
    input  logic [LS_W-1:0] ls_err,
    input  logic            rx_at_trig,
    input  logic            rx_tmo,
    input  logic            thr_empty,
    input  logic [MS_W-1:0] ms_delta,
    input  logic            rd_lsr,
    input  logic            rd_rbr,
    input  logic            rd_iir,
    input  logic            rd_msr,
    input  logic            wr_thr,
    input  logic            thre_shown,
    output iid_src_t        pend,
    output logic [3:0]      ier_q,
    output logic            fifo_q
);

    logic [NSTICKY-1:0] set_v, clr_v, sticky_q, dfr_q;
    logic               rxlvl_q;
    logic               ack_q;

    always_comb begin
        set_v           = '0;
        set_v[SK_LINE]  = |ls_err;
        set_v[SK_TMO]   = rx_tmo;
        set_v[SK_THRE]  = thr_empty;
        set_v[SK_MODEM] = |ms_delta;
        clr_v           = '0;
        clr_v[SK_LINE]  = rd_lsr;
        clr_v[SK_TMO]   = rd_rbr;
        clr_v[SK_THRE]  = wr_thr | ack_q;
        clr_v[SK_MODEM] = rd_msr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            dfr_q    <= '0;
            rxlvl_q  <= 1'b0;
            ier_q    <= '0;
            fifo_q   <= 1'b0;
            ack_q    <= 1'b0;
        end else if (rd_iir) begin
            dfr_q <= dfr_q | set_v;
            ack_q <= ack_q | thre_shown;
        end else begin
            for (int i = 0; i < NSTICKY; i++) begin
                sticky_q[i] <= (sticky_q[i] & ~clr_v[i]) | set_v[i] | dfr_q[i];
            end
            dfr_q   <= '0;
            ack_q   <= 1'b0;
            rxlvl_q <= rx_at_trig;
            ier_q   <= ier;
            fifo_q  <= fifo_en;
        end
    end

    assign pend.line   = sticky_q[SK_LINE];
    assign pend.rxtmo  = sticky_q[SK_TMO];
    assign pend.rxdata = rxlvl_q;
    assign pend.thre   = sticky_q[SK_THRE];
    assign pend.modem  = sticky_q[SK_MODEM];

    assert_freeze_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && $past(rd_iir) && !$past(rst)) |-> ($stable(sticky_q) && $stable(rxlvl_q)));

endmodule

// File: rtl/uart_iid_enc.sv
module uart_iid_enc
    import uart_iid_pkg::*;
(
    input  iid_src_t   pend,
    input  logic [3:0] ier_q,
    input  logic       fifo_q,
    output iid_byte_t  byte_o,
    output logic       thre_shown
);

    iid_src_t act;

    always_comb begin
        act.line   = pend.line   & ier_q[EN_LINE];
        act.rxtmo  = pend.rxtmo  & ier_q[EN_RX];
        act.rxdata = pend.rxdata & ier_q[EN_RX];
        act.thre   = pend.thre   & ier_q[EN_THRE];
        act.modem  = pend.modem  & ier_q[EN_MODEM];
        byte_o     = iid_encode(act, fifo_q);
        thre_shown = (byte_o.id == ID_THRE) && !byte_o.none;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int LS_W = 4,
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      ier,
    input  logic            fifo_en,
    input  logic [LS_W-1:0] ls_err,
    input  logic            rx_at_trig,
    input  logic            rx_tmo,
    input  logic            thr_empty,
    input  logic [MS_W-1:0] ms_delta,
    input  logic            rd_lsr,
    input  logic            rd_rbr,
    input  logic            rd_iir,
    input  logic            rd_msr,
    input  logic            wr_thr,
    output logic [7:0]      iir_byte,
    output logic            irq
);

    iid_src_t   pend;
    logic [3:0] ier_q;
    logic       fifo_q;
    iid_byte_t  byte_w;
    logic       thre_shown;

    uart_iid_src #(.LS_W(LS_W), .MS_W(MS_W)) u_src (
        .clk(clk), .rst(rst), .ier(ier), .fifo_en(fifo_en),
        .ls_err(ls_err), .rx_at_trig(rx_at_trig), .rx_tmo(rx_tmo),
        .thr_empty(thr_empty), .ms_delta(ms_delta),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir),
        .rd_msr(rd_msr), .wr_thr(wr_thr), .thre_shown(thre_shown),
        .pend(pend), .ier_q(ier_q), .fifo_q(fifo_q)
    );

    uart_iid_enc u_enc (
        .pend(pend), .ier_q(ier_q), .fifo_q(fifo_q),
        .byte_o(byte_w), .thre_shown(thre_shown)
    );

    assign iir_byte = byte_w;
    assign irq      = ~byte_w.none;

    assert_line_top_R2: assert property (@(posedge clk) disable iff (rst)
        (pend.line && ier_q[EN_LINE]) |-> (iir_byte[3:0] == 4'b0110));

    assert_byte_held_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && $past(rd_iir) && !$past(rst)) |-> $stable(iir_byte));

    assert_line_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !rd_iir && !$past(rd_iir) && (ls_err == '0)) |=> (iir_byte[3:1] != 3'b011));

    assert_thre_wr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !rd_iir && !$past(rd_iir) && !thr_empty) |=> (iir_byte[3:0] != 4'b0010));

    assert_modem_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && !rd_iir && !$past(rd_iir) && (ms_delta == '0)) |=> (iir_byte[3:0] != 4'b0000));

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier = 4'h0;
    logic       fifo_en = 1'b0;
    logic [3:0] ls_err = 4'h0;
    logic       rx_at_trig = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] ms_delta = 4'h0;
    logic       rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
    logic [7:0] iir_byte;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst(rst), .ier(ier), .fifo_en(fifo_en), .ls_err(ls_err),
        .rx_at_trig(rx_at_trig), .rx_tmo(rx_tmo), .thr_empty(thr_empty),
        .ms_delta(ms_delta), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir),
        .rd_msr(rd_msr), .wr_thr(wr_thr), .iir_byte(iir_byte), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        checks++;
        if (iir_byte !== exp || irq !== ~exp[0]) begin
            failures++;
            $display("FAIL %s: iir_byte=%02h irq=%b expected iir_byte=%02h irq=%b",
                     req, iir_byte, irq, exp, ~exp[0]);
        end
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset idle", 8'h01);
    endtask

    task automatic t_fifo_bits();
        fifo_en = 1'b1;
        ier = 4'hF;
        tick();
        chk("R3 fifo bits set R4", 8'hC1);
    endtask

    task automatic t_priority();
        ms_delta = 4'b0100; tick(); ms_delta = 4'h0;
        chk("R9 modem set", 8'hC0);
        thr_empty = 1'b1; tick(); thr_empty = 1'b0;
        chk("R2 thre over modem", 8'hC2);
        rx_at_trig = 1'b1; tick();
        chk("R2 rxdata over thre", 8'hC4);
        rx_tmo = 1'b1; tick(); rx_tmo = 1'b0;
        chk("R2 timeout over rxdata", 8'hCC);
        ls_err = 4'b0010; tick(); ls_err = 4'h0;
        chk("R2 line highest", 8'hC6);
        rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
        chk("R6 line cleared", 8'hCC);
        rd_rbr = 1'b1; tick(); rd_rbr = 1'b0;
        chk("R7 timeout cleared", 8'hC4);
        rx_at_trig = 1'b0; tick();
        chk("R7 rxdata level fell", 8'hC2);
        wr_thr = 1'b1; tick(); wr_thr = 1'b0;
        chk("R8 thre write clear", 8'hC0);
        rd_msr = 1'b1; tick(); rd_msr = 1'b0;
        chk("R9 modem cleared", 8'hC1);
    endtask

    task automatic t_mask();
        ier = 4'h0; tick();
        ls_err = 4'b1000; tick(); ls_err = 4'h0;
        chk("R10 line masked", 8'hC1);
        ier = 4'b0100; tick();
        chk("R10 line enabled later", 8'hC6);
        ier = 4'b1011; tick();
        chk("R10 line disabled pending hidden", 8'hC1);
        ier = 4'hF; rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
        chk("R6 clear after reenable", 8'hC1);
    endtask

    task automatic t_freeze();
        thr_empty = 1'b1; tick(); thr_empty = 1'b0;
        chk("R8 thre set", 8'hC2);
        rd_iir = 1'b1;
        #1 chk("R5 read start shows thre", 8'hC2);
        @(negedge clk);
        ls_err = 4'b0001; tick(); ls_err = 4'h0;
        chk("R5 frozen during event", 8'hC2);
        tick();
        chk("R5 still frozen", 8'hC2);
        rd_iir = 1'b0; tick();
        chk("R5 deferred line shown", 8'hC6);
        rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
        chk("R8 thre retired by read", 8'hC1);
    endtask

    task automatic t_thre_kept();
        thr_empty = 1'b1; tick(); thr_empty = 1'b0;
        ls_err = 4'b0100; tick(); ls_err = 4'h0;
        chk("R2 line over thre", 8'hC6);
        rd_iir = 1'b1; tick(); rd_iir = 1'b0; tick();
        chk("R8 line read leaves state", 8'hC6);
        rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
        chk("R8 thre kept when not reported", 8'hC2);
        wr_thr = 1'b1; tick(); wr_thr = 1'b0;
        chk("R8 thre cleared by write", 8'hC1);
    endtask

    task automatic t_set_wins();
        thr_empty = 1'b1; wr_thr = 1'b1; tick(); thr_empty = 1'b0; wr_thr = 1'b0;
        chk("R11 set beats clear", 8'hC2);
        wr_thr = 1'b1; tick(); wr_thr = 1'b0;
        chk("R11 later clear", 8'hC1);
    endtask

    task automatic t_fifo_off();
        fifo_en = 1'b0; tick();
        chk("R3 fifo bits clear", 8'h01);
        ms_delta = 4'b0001; tick(); ms_delta = 4'h0;
        chk("R1 irq with modem", 8'h00);
        rd_msr = 1'b1; tick(); rd_msr = 1'b0;
        chk("R9 modem cleared fifo off", 8'h01);
    endtask

    initial begin
        t_reset();
        t_fifo_bits();
        t_priority();
        t_mask();
        t_freeze();
        t_thre_kept();
        t_set_wins();
        t_fifo_off();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule